// File: doc/BRIEF.md
# Primitive-Root Index Permutation Sequencer

This block produces the index orders needed when a transform of prime length P is recast as a circular convolution. It walks the multiplicative group of nonzero residues modulo P. Each emitted index is the previous one times a fixed step, reduced modulo P. The block puts out one index per clock.

In forward mode the step is the primitive root g, so the indices are g^k mod P. In reverse mode the step is the modular inverse of g, so the indices are g^(-k) mod P. Both modes begin at k = 0, where the index is 1. One mode orders the incoming samples and the other reorders the results. Index 0 never appears, because the zero term is summed separately by the datapath around this block.

A flag marks the half point of the walk. From that position onward, each index is the negative modulo P of the index (P-1)/2 positions earlier. Downstream logic uses this to reuse half of its coefficient table as complex conjugates.

Top module: `idx_perm_seq`

## Requirements
- R1: An accepted start produces exactly P-1 indices on consecutive cycles with `valid_o` high. Within one run the indices are all distinct, and each lies in 1..P-1.
- R2: The first index of every run is 1. It appears with `valid_o` high on the clock cycle after the edge that accepts `start_i`.
- R3: With forward mode (`mode_i` = 0) each following index equals the previous index times G, mod P. For P=61, G=2 the run begins 1, 2, 4, 8, 16, 32, 3, 6, 12, 24, 48, 35.
- R4: With reverse mode (`mode_i` = 1) each following index equals the previous index times G_INV, mod P. Reverse position n carries the forward index at position (P-1-n) mod (P-1).
- R5: `half_o` is high only at run position (P-1)/2, counting the first index as position 0. At that position the index is P-1, and every later index equals P minus the index (P-1)/2 positions earlier.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last index. `valid_o` is low in that cycle.
- R7: While a run is in progress, `start_i` and changes on `mode_i` have no effect. The run keeps its order and its length, and no extra run follows it.
- R8: While `rst_ni` is low, `valid_o`, `half_o` and `done_o` are low and `idx_o` is 0.
- R9: A start raised during the cycle in which `done_o` is high is accepted. The next run then follows with a single idle cycle between the two runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| mode_i | input | 1 | 0 forward (step G), 1 reverse (step G_INV), sampled at start |
| idx_o | output | IDX_W | Current residue index |
| valid_o | output | 1 | `idx_o` holds a run index |
| half_o | output | 1 | Current index is the first of the second half |
| done_o | output | 1 | One-cycle pulse after the last index |

## Verification
Index number k of a run (k from 0) is due k+1 cycles after the rising edge that takes `start_i`. The half flag is due on index (P-1)/2, and `done_o` is due on the cycle after index P-2. The bench drives on falling edges and samples on falling edges. Its monitor pops exactly one expected item for every cycle with `valid_o` high and arms a done check for the very next cycle. A run that starts early or late, or skips or repeats a step, therefore shows up as a value mismatch on the first affected index.

// File: rtl/idx_perm_pkg.sv
package idx_perm_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;
endpackage

// File: rtl/idx_modmul.sv
// Constant-step modular multiply, reduced by a chain of compare-subtract stages.
module idx_modmul #(
  parameter int P     = 61,
  parameter int G     = 2,
  parameter int G_INV = 31,
  localparam int IDX_W = $clog2(P)
) (
  input  logic [IDX_W-1:0] a_i,
  input  logic             rev_i,
  output logic [IDX_W-1:0] r_o
);
  localparam int PW = 2 * IDX_W;

  logic [IDX_W-1:0] mult;
  logic [PW-1:0]    stage [IDX_W+1];

  assign mult         = rev_i ? IDX_W'(G_INV) : IDX_W'(G);
  assign stage[IDX_W] = PW'(a_i) * PW'(mult);

  // product < P * 2^IDX_W, so removing P<<s for s = IDX_W-1..0 leaves the residue
  for (genvar s = IDX_W - 1; s >= 0; s--) begin : g_red
    localparam logic [PW-1:0] SUB = PW'(P) << s;
    assign stage[s] = (stage[s+1] >= SUB) ? stage[s+1] - SUB : stage[s+1];
  end

  assign r_o = IDX_W'(stage[0]);
endmodule

// File: rtl/idx_seq_ctrl.sv
module idx_seq_ctrl
  import idx_perm_pkg::*;
#(
  parameter int P = 61,
  localparam int IDX_W = $clog2(P),
  localparam int CNT_W = $clog2(P - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [IDX_W-1:0] nxt_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             half_o,
  output logic             done_o,
  output logic             rev_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(P - 2);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'((P - 1) / 2);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  dir_e             dir_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      dir_q  <= DIR_FWD;
    end else begin
      done_q <= busy_q && at_last;
      if (busy_q) begin
        if (at_last) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          idx_q <= nxt_i;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        idx_q  <= IDX_W'(1);
        dir_q  <= dir_e'(mode_i);
      end
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = busy_q;
  assign half_o  = busy_q && (cnt_q == HALF_C);
  assign done_o  = done_q;
  assign rev_o   = (dir_q == DIR_REV);
endmodule

// File: rtl/idx_perm_seq.sv
module idx_perm_seq #(
  parameter int P     = 61,
  parameter int G     = 2,
  parameter int G_INV = 31,
  localparam int IDX_W = $clog2(P)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             half_o,
  output logic             done_o
);
  logic [IDX_W-1:0] nxt;
  logic             run_rev;

  idx_seq_ctrl #(.P(P)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mode_i (mode_i),
    .nxt_i  (nxt),
    .idx_o  (idx_o),
    .valid_o(valid_o),
    .half_o (half_o),
    .done_o (done_o),
    .rev_o  (run_rev)
  );

  idx_modmul #(.P(P), .G(G), .G_INV(G_INV)) i_mul (
    .a_i  (idx_o),
    .rev_i(run_rev),
    .r_o  (nxt)
  );
endmodule

// File: rtl/idx_perm_seq_chk.sv
module idx_perm_seq_chk #(
  parameter int P     = 61,
  parameter int G     = 2,
  parameter int G_INV = 31,
  localparam int IDX_W = $clog2(P)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] idx_i,
  input logic             valid_i,
  input logic             half_i,
  input logic             done_i,
  input logic             rev_i
);
  int run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_len <= 0;
    else if (valid_i) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (idx_i != '0) && (int'(idx_i) < P));

  assert_run_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_i) |-> run_len == P - 1);

  assert_first_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> idx_i == IDX_W'(1));

  assert_fwd_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i) && !rev_i) |-> int'(idx_i) == (int'($past(idx_i)) * G) % P);

  assert_rev_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i) && rev_i) |-> int'(idx_i) == (int'($past(idx_i)) * G_INV) % P);

  assert_half_val_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i |-> valid_i && int'(idx_i) == P - 1);

  assert_done_place_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !valid_i && $past(valid_i));

  assert_done_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind idx_perm_seq idx_perm_seq_chk #(.P(P), .G(G), .G_INV(G_INV)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .idx_i  (idx_o),
  .valid_i(valid_o),
  .half_i (half_o),
  .done_i (done_o),
  .rev_i  (run_rev)
);

// File: tb/test_idx_perm_seq.sv
`timescale 1ns/1ps
module test_idx_perm_seq;
  localparam int P     = 61;
  localparam int G     = 2;
  localparam int G_INV = 31;
  localparam int IDX_W = $clog2(P);
  localparam int N     = P - 1;
  localparam int HALF  = (P - 1) / 2;

  typedef struct {
    int    idx;
    bit    half;
    bit    first;
    bit    last;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [IDX_W-1:0] idx_o;
  logic valid_o, half_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit done_due = 0;
  bit [127:0] seen;
  item_t exp_q[$];
  int fwd[N];

  always #2.5 clk = ~clk;

  idx_perm_seq #(.P(P), .G(G), .G_INV(G_INV)) i_idx_perm_seq (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start_i),
    .mode_i (mode_i),
    .idx_o  (idx_o),
    .valid_o(valid_o),
    .half_o (half_o),
    .done_o (done_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // queue the expected run, then raise start at the current falling edge
  task automatic run(bit rev, bit disturb);
    for (int n = 0; n < N; n++) begin
      item_t it;
      it.idx   = rev ? fwd[(N - n) % N] : fwd[n];
      it.half  = (n == HALF);
      it.first = (n == 0);
      it.last  = (n == N - 1);
      it.req   = rev ? "R4" : "R3";
      exp_q.push_back(it);
    end
    start_i = 1'b1;
    mode_i  = rev;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 first valid", int'(valid_o), 1);
    check("R2 first index", int'(idx_o), 1);
    if (disturb) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      mode_i  = ~rev;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
  endtask

  // monitor: one expected item per valid cycle, done due on the next cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_due) begin
        check("R6 done pulse", int'(done_o), 1);
        check("R6 valid low at done", int'(valid_o), 0);
        done_due = 0;
      end else if (done_o) begin
        check("R6 unexpected done", 1, 0);
      end
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected valid", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (it.first) seen = '0;
          check(it.req, int'(idx_o), it.idx);
          check("R5 half flag", int'(half_o), int'(it.half));
          check("R1 distinct", int'(seen[idx_o]), 0);
          seen[idx_o] = 1'b1;
          if (it.last) begin
            check("R1 all visited", int'(seen[P-1:1] == {(P-1){1'b1}}), 1);
            done_due = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    fwd[0] = 1;
    for (int k = 1; k < N; k++) fwd[k] = (fwd[k-1] * G) % P;

    repeat (3) @(negedge clk);
    check("R8 valid in reset", int'(valid_o), 0);
    check("R8 half in reset", int'(half_o), 0);
    check("R8 done in reset", int'(done_o), 0);
    check("R8 idx in reset", int'(idx_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 idle after reset", int'(valid_o), 0);

    run(1'b0, 1'b0);                 // R3 forward
    repeat (3) @(negedge clk);
    run(1'b1, 1'b0);                 // R4 reverse
    repeat (3) @(negedge clk);
    run(1'b0, 1'b1);                 // R7 start and mode change mid-run
    run(1'b1, 1'b1);                 // R9 start during done cycle, R7 again
    run(1'b0, 1'b0);                 // R9 chained once more
    repeat (10) @(negedge clk);
    check("R7 no extra run", exp_q.size(), 0);
    check("R7 idle", int'(valid_o), 0);
    summary();
  end
endmodule